// File: doc/BRIEF.md
# USB OUT Endpoint Receive Control and Status

This block holds the receive-side control and status of a single device-mode USB OUT endpoint. A counter tracks how many received packets are waiting. With the default depth of two, the endpoint is double buffered. Software sees everything through one 8-bit register that has a write strobe and a readback bus. The packet engine reports four things: a packet arrived, that packet had a CRC or bit-stuff error, a STALL handshake went out, and the endpoint is isochronous rather than bulk.

The block drives four outputs back to the engine and the data path: the stall request, the current data toggle, a one-cycle flush command and a receive interrupt. The flags come in three kinds. Some are set by hardware and cleared only when software writes 0. Some are cleared by hardware. Two control bits clear themselves. Software must therefore write 1 to any software-clearable flag it wants to keep. Writing 1 to such a flag never sets it.

Register bit positions, most significant first: 7 toggle-reset, 6 stall-seen, 5 stall-request, 4 flush, 3 data-error, 2 overrun, 1 slots-full, 0 packet-ready.

Top module: `rx_ep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and `send_stall`, `data_toggle`, `flush_fifo` and `rx_irq` are all 0.
- R2: `data_toggle` inverts on each accepted packet. A write with bit 7 = 1 forces it to 0 on the next cycle. Bit 7 then reads 1 for one cycle and 0 afterwards.
- R3: Bit 6 becomes 1 the cycle after `stall_sent` is high. A write with bit 6 = 0 clears it. A write with bit 6 = 1 leaves it unchanged.
- R4: Bit 5 takes the written value on every write, and `send_stall` follows bit 5.
- R5: Bit 0 becomes 1 the cycle after a packet is accepted. A write with bit 0 = 0 clears it. A write with bit 0 = 1 never sets it.
- R6: Up to NUM_SLOTS packets are held. Bit 1 reads 1 exactly when all slots are taken. Clearing bit 0 releases the oldest slot. If a packet remains, bit 0 reads 0 for one cycle and then 1 again.
- R7: A write with bit 4 = 1 releases the oldest packet and clears bit 0. On the next cycle bit 4 reads 1 and `flush_fifo` pulses for one cycle. Two flushes empty a full double buffer.
- R8: In isochronous mode, bit 3 becomes 1 when an accepted packet carries an error. It clears whenever bit 0 is cleared.
- R9: In isochronous mode, a packet that arrives while all slots are full is dropped and sets bit 2. A write with bit 2 = 0 clears bit 2, and a write with bit 2 = 1 leaves it unchanged.
- R10: With `iso_mode` = 0, bits 3 and 2 read 0 and overrun is never recorded.
- R11: `rx_irq` is a one-cycle pulse in the first cycle that bit 0 reads 1 after reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register readback |
| pkt_rcvd | input | 1 | One-cycle strobe: an OUT packet arrived |
| pkt_err | input | 1 | Arriving packet had a CRC or bit-stuff error |
| stall_sent | input | 1 | A STALL handshake was transmitted |
| iso_mode | input | 1 | 1 = isochronous, 0 = bulk |
| send_stall | output | 1 | Answer with STALL handshakes |
| data_toggle | output | 1 | Expected data toggle |
| flush_fifo | output | 1 | One-cycle command to reset the packet read pointer |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench builds the block with NUM_SLOTS = 2, the double-buffered case. At this depth every burst of zero to three packets can be swept. The sweep covers every error pattern and both endpoint modes, so fill, overflow, toggle parity and error accumulation are all covered. Directed sequences add the drain and re-assert behaviour, double flushes, write-one immunity and the self-clearing bits.

// File: rtl/rx_ep_pkg.sv
package rx_ep_pkg;
    localparam int REG_W    = 8;
    localparam int B_CLRTOG = 7;
    localparam int B_STSEEN = 6;
    localparam int B_STREQ  = 5;
    localparam int B_FLUSH  = 4;
    localparam int B_DERR   = 3;
    localparam int B_OVR    = 2;
    localparam int B_FULL   = 1;
    localparam int B_RDY    = 0;

    typedef struct packed {
        logic clrtog;
        logic stall_seen;
        logic stall_req;
        logic flush;
        logic derr;
        logic ovr;
        logic rdy;
        logic tog;
    } ep_flags_t;
endpackage

// File: rtl/rx_slot_count.sv
module rx_slot_count #(
    parameter int NUM_SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_in,
    input  logic release_i,
    output logic accept_o,
    output logic full_o,
    output logic occupied_o
);
    localparam int CW = $clog2(NUM_SLOTS + 1);
    localparam logic [CW-1:0] MAXC = CW'(NUM_SLOTS);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          rel_eff;

    always_comb begin
        full_o     = (cnt_q == MAXC);
        occupied_o = (cnt_q != '0);
        accept_o   = pkt_in && !full_o;
        rel_eff    = release_i && occupied_o;
        cnt_d      = cnt_q + CW'(accept_o) - CW'(rel_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rx_irq_edge.sv
module rx_irq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_next,
    input  logic lvl_cur,
    output logic pulse_o
);
    logic pulse_d, pulse_q;

    always_comb pulse_d = lvl_next && !lvl_cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/rx_ep_ctrl.sv
module rx_ep_ctrl
    import rx_ep_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             pkt_rcvd,
    input  logic             pkt_err,
    input  logic             stall_sent,
    input  logic             iso_mode,
    output logic             send_stall,
    output logic             data_toggle,
    output logic             flush_fifo,
    output logic             rx_irq
);
    ep_flags_t f_d, f_q;
    logic      accept, full, occupied, release_req;
    logic      wr_clrtog, wr_flush, wr_keep_rdy, wr_keep_ovr, wr_keep_stall;

    always_comb begin
        wr_clrtog     = reg_wr && reg_wdata[B_CLRTOG];
        wr_flush      = reg_wr && reg_wdata[B_FLUSH];
        wr_keep_rdy   = reg_wdata[B_RDY];
        wr_keep_ovr   = reg_wdata[B_OVR];
        wr_keep_stall = reg_wdata[B_STSEEN];
        release_req   = f_q.rdy && reg_wr && (!wr_keep_rdy || reg_wdata[B_FLUSH]);
    end

    rx_slot_count #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .pkt_in     (pkt_rcvd),
        .release_i  (release_req),
        .accept_o   (accept),
        .full_o     (full),
        .occupied_o (occupied)
    );

    always_comb begin
        f_d = f_q;
        // self-clearing controls
        f_d.clrtog = wr_clrtog;
        f_d.flush  = wr_flush;
        // stall request: plain read/write
        if (reg_wr) f_d.stall_req = reg_wdata[B_STREQ];
        // stall seen: hardware set, software clear by writing 0
        if (stall_sent)                  f_d.stall_seen = 1'b1;
        else if (reg_wr && !wr_keep_stall) f_d.stall_seen = 1'b0;
        // overrun: only recorded in isochronous mode
        if (pkt_rcvd && full && iso_mode) f_d.ovr = 1'b1;
        else if (reg_wr && !wr_keep_ovr)  f_d.ovr = 1'b0;
        // packet ready and its companion error flag
        if (release_req) begin
            f_d.rdy  = 1'b0;
            f_d.derr = 1'b0;
        end else begin
            f_d.rdy = f_q.rdy || occupied || accept;
            if (accept && pkt_err && iso_mode) f_d.derr = 1'b1;
        end
        // data toggle
        if (wr_clrtog)   f_d.tog = 1'b0;
        else if (accept) f_d.tog = !f_q.tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    rx_irq_edge u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_next (f_d.rdy),
        .lvl_cur  (f_q.rdy),
        .pulse_o  (rx_irq)
    );

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[B_CLRTOG] = f_q.clrtog;
        reg_rdata[B_STSEEN] = f_q.stall_seen;
        reg_rdata[B_STREQ]  = f_q.stall_req;
        reg_rdata[B_FLUSH]  = f_q.flush;
        reg_rdata[B_DERR]   = f_q.derr && iso_mode;
        reg_rdata[B_OVR]    = f_q.ovr && iso_mode;
        reg_rdata[B_FULL]   = full;
        reg_rdata[B_RDY]    = f_q.rdy;
    end

    assign send_stall  = f_q.stall_req;
    assign data_toggle = f_q.tog;
    assign flush_fifo  = f_q.flush;
endmodule

// File: rtl/rx_ep_ctrl_chk.sv
module rx_ep_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       stall_sent,
    input logic       iso_mode,
    input logic       send_stall,
    input logic       data_toggle,
    input logic       rx_irq
);
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] && !reg_wr |=> reg_rdata[1]); // R6
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> reg_rdata[0] && !$past(reg_rdata[0])); // R11
    AST_STALL_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_rdata[6] && !stall_sent |=> !reg_rdata[6]); // R3
    AST_CLRTOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_wdata[7] |=> !data_toggle); // R2
    AST_FLUSH_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[4] && !(reg_wr && reg_wdata[4]) |=> !reg_rdata[4]); // R7
    AST_BULK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !iso_mode |-> reg_rdata[3:2] == 2'b00); // R10
    AST_RDY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_rdata[0] && !reg_wdata[0] |=> !reg_rdata[0]); // R5
    AST_STALL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> send_stall == $past(reg_wdata[5])); // R4
endmodule

bind rx_ep_ctrl rx_ep_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .stall_sent  (stall_sent),
    .iso_mode    (iso_mode),
    .send_stall  (send_stall),
    .data_toggle (data_toggle),
    .rx_irq      (rx_irq)
);

// File: tb/rx_ep_ctrl_tb.sv
`timescale 1ns/1ps
module rx_ep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       pkt_rcvd = 1'b0, pkt_err = 1'b0, stall_sent = 1'b0, iso_mode = 1'b0;
    logic       send_stall, data_toggle, flush_fifo, rx_irq;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    rx_ep_ctrl #(.NUM_SLOTS(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pkt_rcvd(pkt_rcvd), .pkt_err(pkt_err),
        .stall_sent(stall_sent), .iso_mode(iso_mode), .send_stall(send_stall),
        .data_toggle(data_toggle), .flush_fifo(flush_fifo), .rx_irq(rx_irq)
    );

    task automatic check(input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        tick();
        reg_wr = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic pkt(input logic e);
        pkt_rcvd = 1'b1;
        pkt_err = e;
        tick();
        pkt_rcvd = 1'b0;
        pkt_err = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        check(reg_rdata, 0, "R1 register after reset");
        check({send_stall, data_toggle, flush_fifo, rx_irq}, 0, "R1 outputs after reset");

        // R5: write 1 cannot set packet-ready
        wr(8'h01);
        check(reg_rdata[0], 0, "R5 write one no set");

        // R11 interrupt pulse
        pkt(1'b0);
        check(reg_rdata[0], 1, "R5 ready after packet");
        check(rx_irq, 1, "R11 irq pulse high");
        tick();
        check(rx_irq, 0, "R11 irq pulse one cycle");

        // R2 toggle clear
        check(data_toggle, 1, "R2 toggle after one packet");
        wr(8'h81);
        check(data_toggle, 0, "R2 toggle forced zero");
        check(reg_rdata[7], 1, "R2 clear bit visible one cycle");
        tick();
        check(reg_rdata[7], 0, "R2 clear bit self clears");
        check(reg_rdata[0], 1, "R5 ready kept by write one");

        // R3 stall seen
        stall_sent = 1'b1;
        tick();
        stall_sent = 1'b0;
        check(reg_rdata[6], 1, "R3 stall seen set");
        wr(8'h41);
        check(reg_rdata[6], 1, "R3 write one keeps");
        wr(8'h01);
        check(reg_rdata[6], 0, "R3 write zero clears");
        wr(8'h41);
        check(reg_rdata[6], 0, "R3 write one no set");

        // R4 stall request
        wr(8'h21);
        check(send_stall, 1, "R4 send_stall on");
        check(reg_rdata[5], 1, "R4 readback on");
        wr(8'h01);
        check(send_stall, 0, "R4 send_stall off");

        // R7 double flush
        do_reset();
        pkt(1'b0);
        pkt(1'b0);
        check(reg_rdata[1], 1, "R6 full with two");
        wr(8'h11);
        check(reg_rdata[0], 0, "R7 flush clears ready");
        check(reg_rdata[4], 1, "R7 flush bit visible");
        check(flush_fifo, 1, "R7 flush pulse");
        check(reg_rdata[1], 0, "R7 slot freed");
        tick();
        check(reg_rdata[0], 1, "R6 ready reasserts");
        check(reg_rdata[4], 0, "R7 flush self clears");
        check(flush_fifo, 0, "R7 flush pulse one cycle");
        wr(8'h11);
        tick();
        check(reg_rdata[0], 0, "R7 empty after two flushes");

        // R9 overrun clear
        do_reset();
        iso_mode = 1'b1;
        pkt(1'b0); pkt(1'b0); pkt(1'b0);
        check(reg_rdata[2], 1, "R9 overrun set");
        wr(8'h05);
        check(reg_rdata[2], 1, "R9 write one keeps overrun");
        wr(8'h01);
        check(reg_rdata[2], 0, "R9 write zero clears overrun");

        // Sweep: mode x burst length x error pattern
        for (int iso = 0; iso < 2; iso++) begin
            for (int np = 0; np < 4; np++) begin
                for (int em = 0; em < (1 << np); em++) begin
                    int acc, eacc;
                    do_reset();
                    iso_mode = iso[0];
                    acc = (np > 2) ? 2 : np;
                    eacc = 0;
                    for (int k = 0; k < np; k++) begin
                        pkt(em[k]);
                        if (k < 2 && em[k]) eacc = 1;
                    end
                    check(reg_rdata[0], acc > 0, "R5 sweep ready");
                    check(reg_rdata[1], acc == 2, "R6 sweep full");
                    check(data_toggle, acc % 2, "R2 sweep toggle parity");
                    check(reg_rdata[3], iso & eacc, "R8 R10 sweep data error");
                    check(reg_rdata[2], iso & (np > 2), "R9 R10 sweep overrun");
                    if (acc > 0) begin
                        wr(8'h44);
                        check(reg_rdata[0], 0, "R6 sweep drain clears ready");
                        check(reg_rdata[3], 0, "R8 sweep error cleared");
                        check(reg_rdata[1], 0, "R6 sweep not full after drain");
                        tick();
                        check(reg_rdata[0], acc > 1, "R6 sweep ready reasserts");
                        check(rx_irq, acc > 1, "R11 sweep irq on reassert");
                    end
                end
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule